// File: doc/BRIEF.md
# Watchdog Timer with Two-Byte Service Sequence

This block is a down-counting supervision timer. Software programs a timeout constant, sets an enable bit and optionally a reset-enable bit in a mode register, and then services the timer. A service is two consecutive writes to the feed register: first 0xAA, then 0x55. Only a completed service reloads the counter from the timeout constant and starts it. The counter steps down once every `PRESCALE` clock cycles. If it runs out, the block sets a sticky timeout flag. When reset-enable is set, it also drives a chip reset pulse of fixed length.

The timeout flag is not cleared by the reset pulse the block itself produces. After a restart, software can therefore read the mode register and tell a watchdog restart from a power-on. The enable bits are set-only from software. The pulse that the block issues clears them, as a chip reset would, and so does the block's own reset input. Writes to the timeout constant take effect at the next completed service, not before.

Top module: `wdog_feedseq`

## Requirements
- R1: After `rst_n` is released, `chip_rst_o` is low and the mode (address 0), timeout constant (address 1) and counter (address 3) registers all read 0. Address 2 (feed) always reads 0.
- R2: With enable set, a write of 0xAA (low byte) to address 2 followed by a write of 0x55 to address 2 on the next bus access loads the counter with the timeout constant. The counter reads back that value in the cycle after the 0x55 write.
- R3: The service is abandoned, and the counter is not reloaded, if any other access (read or write, any address) falls between the two bytes or if the second byte is not 0x55.
- R4: Mode bit 0 (enable) and bit 1 (reset-enable) are set by writing 1 and are not cleared by writing 0.
- R5: Setting the enable bit alone does not start counting; the counter holds until the first completed service.
- R6: Once running, the counter drops by exactly one every `PRESCALE` cycles. The first step comes `PRESCALE` cycles after the load.
- R7: With reset-enable set, `chip_rst_o` rises `PRESCALE*(T+1)` cycles after the load of constant T and stays high for exactly `RST_LEN` cycles.
- R8: Expiry sets mode bit 2 (timeout flag). The flag stays set through the reset pulse, while the pulse clears bits 0 and 1. Writing 1 to bit 2 clears the flag, and `rst_n` clears it as well.
- R9: Expiry with reset-enable clear sets the flag, drives no reset, and leaves the counter stopped at 0.
- R10: A completed service while the enable bit is clear is ignored.
- R11: Writing the timeout constant does not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock, also the register clock |
| rst_n | input | 1 | Active-low full reset; clears every register including the flag |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 mode, 1 timeout constant, 2 feed, 3 counter |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected register (combinational) |
| chip_rst_o | output | 1 | Active-high chip reset pulse on expiry |

## Verification
A fault in the service tracker shows up as a counter value that is out of line with the cycle count at the next read. A tracker that stays armed across an intervening access reloads the counter to the full constant. One that never arms leaves the counter stepping down. Either way the error is visible one cycle after the second byte. A prescaler or counter fault moves the first edge of `chip_rst_o` away from `PRESCALE*(T+1)` cycles after the load. A fault in the mode bits appears in the mode read after the pulse, where bit 2 must be 1 and bits 0 and 1 must be 0.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_MODE   = 2'd0,
      REG_TCONST = 2'd1,
      REG_FEED   = 2'd2,
      REG_COUNT  = 2'd3
   } wdog_reg_e;

   localparam logic [7:0] KEY_FIRST  = 8'hAA;
   localparam logic [7:0] KEY_SECOND = 8'h55;

   localparam int MB_EN   = 0;
   localparam int MB_RST  = 1;
   localparam int MB_FLAG = 2;
endpackage

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq
   import wdog_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       access,
   input  logic       feed_wr,
   input  logic [7:0] key,
   output logic       feed_ok
);
   logic armed_q;

   assign feed_ok = armed_q && feed_wr && (key == KEY_SECOND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (access) begin
         // any access either arms (first key) or disarms the tracker
         armed_q <= feed_wr && (key == KEY_FIRST);
      end
   end
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_bypass
         assign tick = run;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pre_q;

         assign tick = run && (pre_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (clr) begin
               pre_q <= '0;
            end else if (run) begin
               pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             running,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   assign expire  = run_q && tick && (cnt_q == '0) && !load;
   assign cnt     = cnt_q;
   assign running = run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         cnt_q <= load_val;
         run_q <= 1'b1;
      end else if (expire) begin
         run_q <= 1'b0;
      end else if (run_q && tick) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/wdog_reset_pulse.sv
module wdog_reset_pulse #(
   parameter int LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active,
   output logic done
);
   localparam int LW = (LEN > 1) ? $clog2(LEN) : 1;
   localparam logic [LW-1:0] LAST = LW'(LEN - 1);

   logic [LW-1:0] len_q;
   logic          act_q;

   assign active = act_q;
   assign done   = act_q && (len_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         len_q <= '0;
      end else if (start) begin
         act_q <= 1'b1;
         len_q <= '0;
      end else if (done) begin
         act_q <= 1'b0;
         len_q <= '0;
      end else if (act_q) begin
         len_q <= len_q + 1'b1;
      end
   end
endmodule

// File: rtl/wdog_feedseq.sv
module wdog_feedseq
   import wdog_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 24,
   parameter int PRESCALE = 4,
   parameter int RST_LEN  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              chip_rst_o
);
   generate
      if (CNT_W > DATA_W || CNT_W < 1) begin : g_bad_cnt_w
         $error("wdog_feedseq: CNT_W must be 1..DATA_W");
      end
      if (DATA_W < 8) begin : g_bad_data_w
         $error("wdog_feedseq: DATA_W must hold a feed byte");
      end
      if (PRESCALE < 1) begin : g_bad_div
         $error("wdog_feedseq: PRESCALE must be at least 1");
      end
      if (RST_LEN < 1) begin : g_bad_len
         $error("wdog_feedseq: RST_LEN must be at least 1");
      end
   endgenerate

   logic             en_q, rst_en_q, flag_q;
   logic [CNT_W-1:0] tconst_q;
   logic [CNT_W-1:0] cnt;
   logic             running, expire, tick;
   logic             feed_ok, load_ok;
   logic             pulse_active, pulse_done, pulse_start;
   logic             wr_ok, access;

   // writes are dropped while the block is holding the chip in reset
   assign wr_ok   = bus_wr && !pulse_active;
   assign access  = wr_ok || bus_rd;
   assign load_ok = feed_ok && en_q && !pulse_active;
   assign pulse_start = expire && rst_en_q;

   wdog_feed_seq i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .access  (access),
      .feed_wr (wr_ok && (bus_addr == REG_FEED)),
      .key     (bus_wdata[7:0]),
      .feed_ok (feed_ok)
   );

   wdog_prescaler #(.DIV(PRESCALE)) i_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (load_ok),
      .run   (running),
      .tick  (tick)
   );

   wdog_down_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_ok),
      .load_val (tconst_q),
      .tick     (tick),
      .cnt      (cnt),
      .running  (running),
      .expire   (expire)
   );

   wdog_reset_pulse #(.LEN(RST_LEN)) i_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (pulse_start),
      .active (pulse_active),
      .done   (pulse_done)
   );

   assign chip_rst_o = pulse_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         rst_en_q <= 1'b0;
         flag_q   <= 1'b0;
         tconst_q <= '0;
      end else begin
         if (pulse_done) begin
            en_q     <= 1'b0;
            rst_en_q <= 1'b0;
         end else if (wr_ok && bus_addr == REG_MODE) begin
            en_q     <= en_q     | bus_wdata[MB_EN];
            rst_en_q <= rst_en_q | bus_wdata[MB_RST];
         end
         if (expire) begin
            flag_q <= 1'b1;
         end else if (wr_ok && bus_addr == REG_MODE && bus_wdata[MB_FLAG]) begin
            flag_q <= 1'b0;
         end
         if (wr_ok && bus_addr == REG_TCONST) begin
            tconst_q <= bus_wdata[CNT_W-1:0];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         REG_MODE: begin
            bus_rdata[MB_EN]   = en_q;
            bus_rdata[MB_RST]  = rst_en_q;
            bus_rdata[MB_FLAG] = flag_q;
         end
         REG_TCONST: bus_rdata[CNT_W-1:0] = tconst_q;
         REG_COUNT:  bus_rdata[CNT_W-1:0] = cnt;
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdog_feedseq_chk.sv
module wdog_feedseq_chk #(
   parameter int CNT_W   = 24,
   parameter int RST_LEN = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             chip_rst_o,
   input logic             en_q,
   input logic             rst_en_q,
   input logic             flag_q,
   input logic             load_ok,
   input logic             running,
   input logic [CNT_W-1:0] cnt
);
   localparam int HW = $clog2(RST_LEN + 1) + 1;
   logic [HW-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hi_cnt <= '0;
      else if (chip_rst_o) hi_cnt <= hi_cnt + 1'b1;
      else                 hi_cnt <= '0;
   end

   AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chip_rst_o) |-> hi_cnt == HW'(RST_LEN));                       // R7
   AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      chip_rst_o |-> hi_cnt < HW'(RST_LEN));                               // R7
   AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(en_q) || $fell(rst_en_q)) |-> $past(chip_rst_o));             // R4
   AST_FLAG_WITH_RST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chip_rst_o) |-> flag_q);                                       // R8
   AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chip_rst_o) |-> $past(rst_en_q));                              // R9
   AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load_ok) |-> cnt <= $past(cnt));                              // R3
   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(running) && !$past(load_ok)) |-> ($past(cnt) - cnt) <= 1);    // R6
endmodule

bind wdog_feedseq wdog_feedseq_chk #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chip_rst_o (chip_rst_o),
   .en_q       (en_q),
   .rst_en_q   (rst_en_q),
   .flag_q     (flag_q),
   .load_ok    (load_ok),
   .running    (running),
   .cnt        (cnt)
);

// File: tb/test_wdog_feedseq.sv
module test_wdog_feedseq;
   localparam int DW = 32;
   localparam int PS = 4;
   localparam int RL = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0]    bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          chip_rst_o;

   int total = 0, bad = 0;
   int rst_hi_cycles = 0;
   bit finished = 0;

   typedef struct {
      logic [DW-1:0] exp;
      string         tag;
   } item_t;
   item_t sb[$];

   always #2 clk = ~clk;

   wdog_feedseq #(.DATA_W(DW), .CNT_W(24), .PRESCALE(PS), .RST_LEN(RL)) i_wdog_feedseq (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .chip_rst_o(chip_rst_o)
   );

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // monitor: compares each read against the next expected item
   always @(negedge clk) begin
      if (chip_rst_o) rst_hi_cycles++;
      if (rst_n && bus_rd) begin
         if (sb.size() == 0) begin
            total++; bad++;
            $display("FAIL scoreboard: actual=0x%0h expected=<none>", bus_rdata);
         end else begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, bus_rdata, it.exp);
         end
      end
   end

   // every bus task starts and ends one time unit after a rising edge
   task automatic wr(logic [1:0] a, logic [DW-1:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_exp(logic [1:0] a, logic [DW-1:0] exp, string tag);
      item_t it;
      it.exp = exp; it.tag = tag;
      sb.push_back(it);
      bus_rd = 1'b1; bus_addr = a;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic feed();
      wr(2'd2, 32'hAA);
      wr(2'd2, 32'h55);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
   end

   initial begin
      int n;
      int hi;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      idle(1);
      // R1 reset state
      check("R1 chip_rst_o", {31'd0, chip_rst_o}, 0);
      rd_exp(2'd0, 0, "R1 mode");
      rd_exp(2'd1, 0, "R1 tconst");
      rd_exp(2'd3, 0, "R1 count");
      rd_exp(2'd2, 0, "R1 feed reads 0");
      // R11 constant write leaves counter alone
      wr(2'd1, 5);
      rd_exp(2'd3, 0, "R11 count after tconst write");
      // R10 feed while disabled
      feed();
      rd_exp(2'd3, 0, "R10 feed ignored while disabled");
      // R5 enable alone does not count
      wr(2'd0, 32'h1);
      idle(8);
      rd_exp(2'd3, 0, "R5 no count before feed");
      // R4 writing zeros keeps enable
      wr(2'd0, 32'h0);
      rd_exp(2'd0, 32'h1, "R4 enable sticky");
      // R2 valid feed, n=0 at the read
      feed();
      rd_exp(2'd3, 5, "R2 load on feed");
      idle(7);
      rd_exp(2'd3, 3, "R6 two steps after 8 cycles");       // n=8
      // R3 intervening access
      wr(2'd2, 32'hAA);                                      // n=9
      rd_exp(2'd0, 32'h1, "R3 intervening read");            // n=10
      wr(2'd2, 32'h55);                                      // n=11
      rd_exp(2'd3, 2, "R3 no reload after interruption");    // n=12
      // R3 wrong second byte
      wr(2'd2, 32'hAA);                                      // n=13
      wr(2'd2, 32'h56);                                      // n=14
      wr(2'd2, 32'h55);                                      // n=15
      rd_exp(2'd3, 1, "R3 no reload after wrong byte");      // n=16
      // R9 expiry without reset-enable at n=24
      idle(13);
      rd_exp(2'd3, 0, "R9 counter stopped at 0");            // n=30
      rd_exp(2'd0, 32'h5, "R9 flag set, enable kept");
      check("R9 no reset pulse", rst_hi_cycles, 0);
      idle(6);
      rd_exp(2'd3, 0, "R9 counter still 0");
      // R8 clear flag by writing 1 to bit 2
      wr(2'd0, 32'h4);
      rd_exp(2'd0, 32'h1, "R8 flag write-1-clear");
      // R7 reset path, T=3
      wr(2'd0, 32'h3);
      wr(2'd1, 3);
      rd_exp(2'd0, 32'h3, "R4 reset-enable set");
      feed();
      n = 0;
      while (!chip_rst_o && n < 1000) begin
         @(posedge clk); #1; n++;
      end
      check("R7 rise delay", n, PS * (3 + 1));
      hi = 0;
      while (chip_rst_o && hi < 1000) begin
         @(posedge clk); #1; hi++;
      end
      check("R7 pulse length", hi, RL);
      rd_exp(2'd0, 32'h4, "R8 flag kept, enables cleared");
      rd_exp(2'd3, 0, "R8 counter 0 after pulse");
      // R10 after pulse, enable is clear so a feed is ignored
      feed();
      rd_exp(2'd3, 0, "R10 feed ignored after pulse");
      // R1 full reset clears flag
      @(posedge clk); #1 rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
      rd_exp(2'd0, 0, "R1 flag cleared by full reset");
      rd_exp(2'd1, 0, "R1 tconst cleared");
      idle(2);
      if (sb.size() != 0) begin
         total++; bad++;
         $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
      end
      summary();
   end
endmodule